// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the arithmetic core of a 24-bit fixed-point signal processor. Four 24-bit operand slots are loaded through a write port. An issued operation takes two of them and multiplies them. Each operand is read as either two's-complement or unsigned. The product can be doubled for fractional (1.23 x 1.23) arithmetic. It is then added to, or subtracted from, one of two 56-bit accumulators, or it replaces that accumulator's contents.

Each accumulator is laid out as an 8-bit extension, a 24-bit high word and a 24-bit low word. Rounding of the low word into the high word is optional and convergent. A second port reads either accumulator as a saturated 24-bit value, with a flag that shows when saturation was applied.

The operation runs in two pipeline stages. The multiply happens in the issue cycle and the accumulate in the next, so one operation can be issued every cycle. A result feeds the very next operation on the same accumulator with no stall. A one-cycle flag reports 56-bit signed overflow.

Top module: `frac_mac`

## Requirements
- R1: The product is opnd[sel_a] x opnd[sel_b]. Slot codes are 0..3. Each operand is sign-extended when its `sgn_a`/`sgn_b` bit is 1 and zero-extended when it is 0.
- R2: When `frac` is 1, the product is shifted left by one bit before accumulation. When it is 0, the product is right-justified.
- R3: Bit 0 of `op` selects subtract (1) or add (0). Bit 1 of `op` starts from zero instead of the accumulator. The codes are: 0 = acc+p, 1 = acc-p, 2 = +p, 3 = -p.
- R4: `dst` = 0 writes accumulator A and `dst` = 1 writes accumulator B. The other accumulator keeps its value.
- R5: An operation issued at rising edge k is visible on `acc_a`/`acc_b` after edge k+1. Operations may issue on every cycle, and each one sees the result of the one before it.
- R6: With `rnd` = 1, the result has half of a high-word LSB (2^23) added and its low 24 bits cleared. When the discarded bits were exactly 0x800000, bit 24 of the result is forced to 0. With `rnd` = 0 the result is the exact sum, wrapped to 56 bits.
- R7: `rd_data` gives bits 47:24 of the selected accumulator (`rd_sel` 0 = A, 1 = B) when bits 55:47 are all equal. Otherwise it gives 0x7FFFFF for a positive value or 0x800000 for a negative one, with `rd_lim` = 1.
- R8: `ovf` is 1 for exactly the cycle after the write when the true result falls outside the signed 56-bit range. The stored value then wraps.
- R9: After reset, both accumulators and all four slots are zero, and `ovf` and `rd_lim` are 0.
- R10: A slot write on the same edge as an issue that reads that slot gives the issue the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write operand slot |
| wr_sel | input | 2 | Slot to write |
| wr_data | input | 24 | Slot write value |
| issue | input | 1 | Start an operation |
| op | input | 2 | Operation code (R3) |
| dst | input | 1 | Destination accumulator |
| sel_a | input | 2 | First operand slot |
| sel_b | input | 2 | Second operand slot |
| sgn_a | input | 1 | First operand is signed |
| sgn_b | input | 1 | Second operand is signed |
| frac | input | 1 | Fractional product shift |
| rnd | input | 1 | Convergent rounding |
| rd_sel | input | 1 | Accumulator for limited readout |
| rd_data | output | 24 | Saturated 24-bit readout |
| rd_lim | output | 1 | Readout was saturated |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| ovf | output | 1 | Overflow pulse |

## Verification
On every cycle the assertions check the following: accumulators hold while no operation is in the second stage, and only the chosen destination changes. A rounded write leaves a zero low word, and a saturated readout takes one of the two limit codes. An overflow pulse always follows a live second stage. The actual numbers can only be shown by the bench scenarios. These cover a sweep of corner operands over every signedness pairing, both product scalings, all four operation codes and both rounding settings. The scenarios also cover rounding ties, back-to-back bursts that drive an accumulator into saturation and wrap, and a slot rewrite that coincides with an issue.

// File: rtl/frac_mac.sv
module frac_mac #(
  parameter int DW = 24,
  parameter int EW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [DW-1:0]          wr_data,
  input  logic                   issue,
  input  logic [1:0]             op,
  input  logic                   dst,
  input  logic [1:0]             sel_a,
  input  logic [1:0]             sel_b,
  input  logic                   sgn_a,
  input  logic                   sgn_b,
  input  logic                   frac,
  input  logic                   rnd,
  input  logic                   rd_sel,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_lim,
  output logic [EW+2*DW-1:0]     acc_a,
  output logic [EW+2*DW-1:0]     acc_b,
  output logic                   ovf
);
  localparam int AW = EW + 2*DW;
  localparam int PW = 2*DW + 2;
  localparam logic [AW:0] HALF  = {{(AW+1-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
  localparam logic [AW:0] LOMSK = {{(AW+1-DW){1'b0}}, {DW{1'b1}}};
  localparam logic [AW:0] TIEB  = {{(AW-DW){1'b0}}, 1'b1, {DW{1'b0}}};
  localparam logic [DW-1:0] PMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NMAX = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] opnd [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) opnd[i] <= '0;
    end else if (wr_en) begin
      opnd[wr_sel] <= wr_data;
    end
  end

  // stage 1: operand extension and multiply
  logic [DW-1:0] va, vb;
  logic [PW-1:0] xa, xb, pm, pf;
  assign va = opnd[sel_a];
  assign vb = opnd[sel_b];
  assign xa = {{(PW-DW){sgn_a & va[DW-1]}}, va};
  assign xb = {{(PW-DW){sgn_b & vb[DW-1]}}, vb};
  assign pm = xa * xb;
  assign pf = frac ? {pm[PW-2:0], 1'b0} : pm;

  logic          s1_vld, s1_dst, s1_rnd;
  logic [1:0]    s1_op;
  logic [PW-1:0] s1_prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_dst  <= 1'b0;
      s1_rnd  <= 1'b0;
      s1_op   <= '0;
      s1_prod <= '0;
    end else begin
      s1_vld <= issue;
      if (issue) begin
        s1_dst  <= dst;
        s1_rnd  <= rnd;
        s1_op   <= op;
        s1_prod <= pf;
      end
    end
  end

  // stage 2: accumulate, round, write back
  logic [AW-1:0] cur;
  logic [AW:0]   base, pext, sum, rsum, rcut, res;
  logic          tie, over;
  assign cur  = s1_dst ? acc_b : acc_a;
  assign base = s1_op[1] ? '0 : {cur[AW-1], cur};
  assign pext = {{(AW+1-PW){s1_prod[PW-1]}}, s1_prod};
  assign sum  = s1_op[0] ? base - pext : base + pext;
  assign tie  = (sum & LOMSK) == HALF;
  assign rsum = sum + HALF;
  assign rcut = tie ? (rsum & ~LOMSK & ~TIEB) : (rsum & ~LOMSK);
  assign res  = s1_rnd ? rcut : sum;
  assign over = res[AW] ^ res[AW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= s1_vld & over;
      if (s1_vld && !s1_dst) acc_a <= res[AW-1:0];
      if (s1_vld &&  s1_dst) acc_b <= res[AW-1:0];
    end
  end

  // limiter readout
  logic [EW:0]   hi;
  logic [DW-1:0] mid;
  assign hi      = rd_sel ? acc_b[AW-1:2*DW-1] : acc_a[AW-1:2*DW-1];
  assign mid     = rd_sel ? acc_b[2*DW-1:DW]   : acc_a[2*DW-1:DW];
  assign rd_lim  = !((&hi) || !(|hi));
  assign rd_data = rd_lim ? (hi[EW] ? NMAX : PMAX) : mid;

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> ($stable(acc_a) && $stable(acc_b)));
  p_keep_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_dst) |=> $stable(acc_b));
  p_keep_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_dst) |=> $stable(acc_a));
  p_round_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_rnd && !s1_dst) |=> (acc_a[DW-1:0] == '0));
  p_sat_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lim |-> (rd_data == PMAX || rd_data == NMAX));
  p_ovf_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(s1_vld));
endmodule

// File: tb/tb_frac_mac.sv
module tb_frac_mac;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, issue = 0, dst = 0, sgn_a = 0, sgn_b = 0, frac = 0, rnd = 0, rd_sel = 0;
  logic [1:0] wr_sel = 0, op = 0, sel_a = 0, sel_b = 0;
  logic [23:0] wr_data = 0;
  logic [23:0] rd_data;
  logic rd_lim, ovf;
  logic [55:0] acc_a, acc_b;

  frac_mac dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .issue(issue), .op(op), .dst(dst), .sel_a(sel_a), .sel_b(sel_b), .sgn_a(sgn_a), .sgn_b(sgn_b),
    .frac(frac), .rnd(rnd), .rd_sel(rd_sel), .rd_data(rd_data), .rd_lim(rd_lim),
    .acc_a(acc_a), .acc_b(acc_b), .ovf(ovf));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  longint ma = 0, mb = 0;
  bit last_ov = 0;
  logic [23:0] regs [4] = '{default: 24'h0};
  longint ha [80], hb [80];
  bit ho [80];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint prod(logic [23:0] a, logic [23:0] b, bit sa, bit sb, bit fr);
    longint x = longint'(a);
    longint y = longint'(b);
    if (sa && a[23]) x -= 64'sd16777216;
    if (sb && b[23]) y -= 64'sd16777216;
    return fr ? (x * y) * 2 : x * y;
  endfunction

  function automatic longint stepf(longint acc, longint p, int o, bit rn);
    longint base = (o >= 2) ? 64'sd0 : acc;
    longint s = (o % 2 == 1) ? base - p : base + p;
    longint r;
    if (!rn) return s;
    r = (s + 64'sh800000) & ~64'shFFFFFF;
    if ((s & 64'shFFFFFF) == 64'sh800000) r = r & ~64'sh1000000;
    return r;
  endfunction

  task automatic cmp_all(string tag, longint ea, longint eb, bit eo);
    longint src = rd_sel ? eb : ea;
    longint top = src >>> 47;
    logic [23:0] ed;
    bit el;
    chk({tag, " R5 acc_a"}, {8'h0, acc_a}, {8'h0, ea[55:0]});
    chk({tag, " R4 acc_b"}, {8'h0, acc_b}, {8'h0, eb[55:0]});
    chk({tag, " R8 ovf"}, {63'h0, ovf}, {63'h0, eo});
    if (top == 0 || top == -1) begin el = 0; ed = src[47:24]; end
    else begin el = 1; ed = (src < 0) ? 24'h800000 : 24'h7FFFFF; end
    chk({tag, " R7 rd_data"}, {40'h0, rd_data}, {40'h0, ed});
    chk({tag, " R7 rd_lim"}, {63'h0, rd_lim}, {63'h0, el});
  endtask

  task automatic wr(int s, logic [23:0] v);
    wr_en = 1; wr_sel = 2'(s); wr_data = v;
    @(negedge clk);
    wr_en = 0; regs[s] = v;
  endtask

  task automatic iss(int ia, int ib, bit sa, bit sb, bit fr, int o, bit d, bit rn);
    longint p = prod(regs[ia], regs[ib], sa, sb, fr);
    longint r = stepf(d ? mb : ma, p, o, rn);
    longint w = (r <<< 8) >>> 8;
    last_ov = (r > 64'sh7FFFFFFFFFFFFF) || (r < -64'sh80000000000000);
    if (d) mb = w; else ma = w;
    issue = 1; sel_a = 2'(ia); sel_b = 2'(ib); sgn_a = sa; sgn_b = sb; frac = fr;
    op = 2'(o); dst = d; rnd = rn; rd_sel = d;
    @(negedge clk);
    issue = 0;
  endtask

  task automatic burst(int n, int mode);
    for (int k = 0; k < n + 2; k++) begin
      if (k >= 2) cmp_all(mode == 0 ? "burst0 R5 R2" : "burst1 R5 R6", ha[k-2], hb[k-2], ho[k-2]);
      if (k < n) begin
        if (mode == 0) iss(0, 1, 0, 0, 1, 0, 0, 0);
        else iss(2, 3, 1, 1, k % 3 == 0, k % 4, k % 2 == 1, k % 2 == 0);
        ha[k] = ma; hb[k] = mb; ho[k] = last_ov;
      end else @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R5 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [23:0] vals [6] = '{24'h000000, 24'h000001, 24'h7FFFFF, 24'h800000, 24'hFFFFFF, 24'h5A3C91};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_all("reset R9", 0, 0, 0);

    // R10: write slot 0 on the same edge as an issue reading it
    wr(0, 24'h000003); wr(1, 24'h000005);
    wr_en = 1; wr_sel = 0; wr_data = 24'h000100;
    iss(0, 1, 1, 1, 0, 2, 0, 0);
    wr_en = 0; regs[0] = 24'h000100;
    @(negedge clk);
    cmp_all("R10 old value", ma, mb, last_ov);
    chk("R10 acc_a=15", {8'h0, acc_a}, 64'd15);
    iss(0, 1, 1, 1, 0, 2, 0, 0); @(negedge clk);
    chk("R10 new value", {8'h0, acc_a}, 64'h500);

    // R6 rounding ties and a non-tie
    wr(0, 24'h800000); wr(1, 24'h000001); wr(2, 24'h000003);
    iss(0, 1, 0, 0, 0, 2, 0, 1); @(negedge clk);
    chk("R6 tie to even 0", {8'h0, acc_a}, 64'h0);
    iss(0, 2, 0, 0, 0, 2, 0, 1); @(negedge clk);
    chk("R6 tie to even 2", {8'h0, acc_a}, 64'h2000000);
    iss(0, 1, 0, 0, 0, 3, 1, 1); @(negedge clk);
    cmp_all("R6 negative tie", ma, mb, last_ov);
    wr(1, 24'h000002);
    iss(0, 1, 0, 0, 1, 2, 1, 0); @(negedge clk);
    chk("R2 frac doubles", {8'h0, acc_b}, 64'h2000000);

    // sweep R1 R2 R3 R4 R6 over corner operands
    begin
      int k = 0;
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int s = 0; s < 4; s++)
            for (int f = 0; f < 2; f++) begin
              int ia = k % 4, ib = (k / 4) % 4;
              wr(ia, vals[i]);
              if (ib != ia) wr(ib, vals[j]);
              iss(ia, ib, s[0], s[1], f[0], (k / 3) % 4, ((k / 5) % 2) == 1, ((k / 2) % 2) == 1);
              @(negedge clk);
              cmp_all("sweep R1 R3", ma, mb, last_ov);
              k++;
            end
    end

    // back-to-back: saturation and wrap on A (R7 R8)
    wr(0, 24'hFFFFFF); wr(1, 24'hFFFFFF);
    iss(0, 1, 0, 0, 1, 2, 0, 0); @(negedge clk);
    burst(70, 0);
    wr(2, 24'h800000); wr(3, 24'h400001);
    burst(40, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule